// File: doc/BRIEF.md
# Eight-Bit GPIO Port with Edge Interrupts

This block is a per-bit configurable general-purpose I/O port. A small register bus writes and reads eight configuration and status registers, all of them eight bits wide. The configuration registers set direction, output value, pull resistor enable, peripheral hand-over, interrupt edge polarity and interrupt enable. The pad side carries an output value, an output enable, pull-up and pull-down requests, and a raw input. The peripheral side supplies an output value and a direction for bits handed over to it, and it receives the synchronized input level.

Each pad input passes through two flops before any other use. A third flop holds the previous synchronized sample, and edges are found by comparing the two. When a bit sees its selected edge, its interrupt flag latches. The single interrupt request is the OR over the bits whose flag and enable are both set. Software clears a flag by writing 0 to it. An edge that arrives in the same cycle as the clearing write takes priority.

Top module: `gpio_edge_port`

## Requirements
- R1: While reset is held and after it is released, every configuration register, flag and enable reads 0, `pad_oe` is 0, both pull requests are 0 and `irq` is 0.
- R2: Register map, selected by `bus_addr`: 1 output value, 2 direction (1 = output), 3 pull enable, 4 peripheral select, 5 edge select, 6 interrupt enable, 7 flags. Addresses 1 to 6 read back what was written. Address 0 reads the synchronized input, and writes to it are ignored.
- R3: For a bit with peripheral select 0, `pad_oe` equals the direction bit and `pad_out` equals the output value bit. For a bit with peripheral select 1, `pad_oe` equals `mod_dir` and `pad_out` equals `mod_out`.
- R4: When pull enable is 1 and the effective output enable is 0, the output value bit picks the pull: 1 raises `pad_pu`, 0 raises `pad_pd`. In every other case both pull requests are 0.
- R5: Address 0 and `mod_in` show `pad_in` two rising clock edges after it changes, whatever the peripheral select.
- R6: A flag bit sets on the third rising edge after its pad changes, if the change matches the edge select bit: 0 selects a low-to-high change and 1 selects a high-to-low change. The other polarity sets nothing.
- R7: Writing address 7 clears the flag bits written as 0 and leaves the bits written as 1 unchanged. If an edge is detected in the same cycle as the clearing write, that flag stays set.
- R8: Changing edge select while the pads are stable sets no flag.
- R9: `irq` is 1 exactly when some bit has both its flag and its enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pad_in | input | 8 | Raw pad levels |
| pad_out | output | 8 | Value driven onto the pads |
| pad_oe | output | 8 | Pad output enable |
| pad_pu | output | 8 | Pull-up request |
| pad_pd | output | 8 | Pull-down request |
| mod_out | input | 8 | Peripheral output value |
| mod_dir | input | 8 | Peripheral direction (1 = output) |
| mod_in | output | 8 | Synchronized input level for the peripheral |
| irq | output | 1 | Combined interrupt request |

## Verification
The pad control path is swept over all 32 combinations of direction, output value, pull enable, peripheral select and peripheral direction. Every bit carries a different combination, so a swapped mux leg or a wrong pull polarity shows up on some bit.

The interrupt path is driven with all-rise, all-fall, mixed and single-bit transitions under several edge select masks. This separates polarity mistakes, crossed bits and off-by-one latency.

Three targeted sequences cover the remaining hazards:
- a clearing write placed exactly on the edge-detect cycle, which must leave the flag set;
- edge select toggling with the pads held still, which must set no flag;
- a write of all ones to the flags, which must set none of them.

// File: rtl/gpio_edge_port.sv
module gpio_edge_port #(
  parameter int WIDTH       = 8,
  parameter bit HAS_MOD_DIR = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [2:0]       bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_pu,
  output logic [WIDTH-1:0] pad_pd,
  input  logic [WIDTH-1:0] mod_out,
  input  logic [WIDTH-1:0] mod_dir,
  output logic [WIDTH-1:0] mod_in,
  output logic             irq
);
  localparam logic [2:0] A_IN   = 3'd0;
  localparam logic [2:0] A_OUT  = 3'd1;
  localparam logic [2:0] A_DIR  = 3'd2;
  localparam logic [2:0] A_PULL = 3'd3;
  localparam logic [2:0] A_FUNC = 3'd4;
  localparam logic [2:0] A_ESEL = 3'd5;
  localparam logic [2:0] A_IE   = 3'd6;
  localparam logic [2:0] A_FLAG = 3'd7;

  logic [WIDTH-1:0] out_q, dir_q, pull_q, func_q, esel_q, ie_q, flag_q;
  logic [WIDTH-1:0] meta_q, sync_q, prev_q;
  logic [WIDTH-1:0] hit, mod_oe, eff_oe, pull_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign hit = (sync_q & ~prev_q & ~esel_q) | (~sync_q & prev_q & esel_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      pull_q <= '0;
      func_q <= '0;
      esel_q <= '0;
      ie_q   <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_OUT:   out_q  <= bus_wdata;
        A_DIR:   dir_q  <= bus_wdata;
        A_PULL:  pull_q <= bus_wdata;
        A_FUNC:  func_q <= bus_wdata;
        A_ESEL:  esel_q <= bus_wdata;
        A_IE:    ie_q   <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag_q <= '0;
    else if (bus_we && bus_addr == A_FLAG)
      flag_q <= (flag_q & bus_wdata) | hit;
    else
      flag_q <= flag_q | hit;
  end

  generate
    if (HAS_MOD_DIR) begin : g_moddir
      assign mod_oe = mod_dir;
    end else begin : g_regdir
      assign mod_oe = dir_q;
    end
  endgenerate

  assign eff_oe  = (func_q & mod_oe) | (~func_q & dir_q);
  assign pad_oe  = eff_oe;
  assign pad_out = (func_q & mod_out) | (~func_q & out_q);
  assign pull_on = pull_q & ~eff_oe;
  assign pad_pu  = pull_on & out_q;
  assign pad_pd  = pull_on & ~out_q;
  assign mod_in  = sync_q;
  assign irq     = |(flag_q & ie_q);

  always_comb begin
    case (bus_addr)
      A_IN:    bus_rdata = sync_q;
      A_OUT:   bus_rdata = out_q;
      A_DIR:   bus_rdata = dir_q;
      A_PULL:  bus_rdata = pull_q;
      A_FUNC:  bus_rdata = func_q;
      A_ESEL:  bus_rdata = esel_q;
      A_IE:    bus_rdata = ie_q;
      default: bus_rdata = flag_q;
    endcase
  end
endmodule

module gpio_edge_port_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic [2:0]       bus_addr,
  input logic [WIDTH-1:0] bus_wdata,
  input logic [WIDTH-1:0] pad_oe,
  input logic [WIDTH-1:0] pad_pu,
  input logic [WIDTH-1:0] pad_pd,
  input logic             irq,
  input logic [WIDTH-1:0] flag_q,
  input logic [WIDTH-1:0] sync_q,
  input logic [WIDTH-1:0] prev_q,
  input logic [WIDTH-1:0] hit
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (pad_oe == '0 && pad_pu == '0 && pad_pd == '0 && irq == 1'b0));

  // R4
  pull_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pu & pad_pd) == '0) && (((pad_pu | pad_pd) & pad_oe) == '0));

  // R6
  flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q & ~$past(flag_q) & ~($past(sync_q) ^ $past(prev_q))) == '0);

  // R7
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd7) |=> ((flag_q & ~$past(bus_wdata) & ~$past(hit)) == '0));
endmodule

bind gpio_edge_port gpio_edge_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
  .irq(irq), .flag_q(flag_q), .sync_q(sync_q), .prev_q(prev_q), .hit(hit)
);

// File: tb/gpio_edge_port_test.sv
`timescale 1ns/1ps
module gpio_edge_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in = 8'h00;
  logic [7:0] pad_out, pad_oe, pad_pu, pad_pd;
  logic [7:0] mod_out = 8'h00;
  logic [7:0] mod_dir = 8'h00;
  logic [7:0] mod_in;
  logic       irq;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_edge_port uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
    .mod_out(mod_out), .mod_dir(mod_dir), .mod_in(mod_in), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic irq_case(input logic [7:0] p0, input logic [7:0] p1,
                          input logic [7:0] esel, input logic [7:0] ie);
    logic [7:0] rise, fall, exp, got;
    pad_in = p0;
    repeat (4) @(negedge clk);
    wr(3'd5, esel);
    wr(3'd6, ie);
    wr(3'd7, 8'h00);
    rd(3'd7, got);
    chk("R7 flags cleared before case", got, 8'h00);
    @(negedge clk);
    pad_in = p1;
    repeat (3) @(negedge clk);
    rise = p1 & ~p0;
    fall = ~p1 & p0;
    exp  = (rise & ~esel) | (fall & esel);
    rd(3'd7, got);
    chk("R6 flags after edge", got, exp);
    chk("R9 irq", {7'd0, irq}, {7'd0, |(exp & ie)});
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    logic [7:0] v_dir, v_out, v_pull, v_func, v_mdir, e_oe, e_po, e_pull;

    repeat (3) @(negedge clk);
    chk("R1 pad_oe in reset", pad_oe, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 1; a < 8; a++) begin
      rd(a[2:0], got);
      chk("R1 register reset value", got, 8'h00);
    end
    chk("R1 pad_oe", pad_oe, 8'h00);
    chk("R1 pulls", pad_pu | pad_pd, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);

    for (int a = 1; a < 7; a++) wr(a[2:0], 8'h11 * a[7:0] ^ 8'hA0);
    for (int a = 1; a < 7; a++) begin
      rd(a[2:0], got);
      chk("R2 readback", got, 8'h11 * a[7:0] ^ 8'hA0);
    end
    for (int a = 1; a < 7; a++) wr(a[2:0], 8'h00);
    pad_in = 8'h3C;
    repeat (3) @(negedge clk);
    wr(3'd0, 8'hFF);
    rd(3'd0, got);
    chk("R2 input address ignores writes", got, 8'h3C);
    wr(3'd7, 8'h00);

    for (int r = 0; r < 4; r++) begin
      for (int b = 0; b < 8; b++) begin
        int c;
        c = r * 8 + b;
        v_dir[b]  = c[0];
        v_out[b]  = c[1];
        v_pull[b] = c[2];
        v_func[b] = c[3];
        v_mdir[b] = c[4];
      end
      mod_out = 8'h5A ^ r[7:0];
      mod_dir = v_mdir;
      wr(3'd1, v_out);
      wr(3'd2, v_dir);
      wr(3'd3, v_pull);
      wr(3'd4, v_func);
      #1;
      e_oe   = (v_func & v_mdir) | (~v_func & v_dir);
      e_po   = (v_func & mod_out) | (~v_func & v_out);
      e_pull = v_pull & ~e_oe;
      chk("R3 pad_oe", pad_oe, e_oe);
      chk("R3 pad_out", pad_out, e_po);
      chk("R4 pad_pu", pad_pu, e_pull & v_out);
      chk("R4 pad_pd", pad_pd, e_pull & ~v_out);
    end
    wr(3'd2, 8'h00);
    wr(3'd3, 8'h00);

    wr(3'd4, 8'hFF);
    @(negedge clk);
    pad_in = 8'hC3;
    @(negedge clk);
    rd(3'd0, got);
    chk("R5 input unchanged after one edge", got, 8'h3C);
    @(negedge clk);
    rd(3'd0, got);
    chk("R5 input after two edges", got, 8'hC3);
    chk("R5 mod_in with peripheral selected", mod_in, 8'hC3);
    wr(3'd4, 8'h00);
    pad_in = 8'h96;
    repeat (3) @(negedge clk);
    chk("R5 mod_in with port selected", mod_in, 8'h96);

    irq_case(8'h00, 8'hFF, 8'h00, 8'hFF);
    irq_case(8'hFF, 8'h00, 8'h00, 8'hFF);
    irq_case(8'h00, 8'hFF, 8'hFF, 8'hFF);
    irq_case(8'hFF, 8'h00, 8'hFF, 8'h0F);
    irq_case(8'h00, 8'hFF, 8'hAA, 8'hF0);
    irq_case(8'hFF, 8'h00, 8'hAA, 8'h00);
    irq_case(8'h0F, 8'hF0, 8'h0F, 8'h81);
    for (int b = 0; b < 8; b++) begin
      irq_case(8'h00, 8'h01 << b, 8'h00, 8'h01 << b);
      irq_case(8'h01 << b, 8'h00, 8'hFF, ~(8'h01 << b));
    end

    pad_in = 8'h00;
    repeat (4) @(negedge clk);
    wr(3'd5, 8'h00);
    wr(3'd6, 8'hFF);
    wr(3'd7, 8'h00);
    @(negedge clk);
    pad_in = 8'h81;
    @(negedge clk);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 3'd7; bus_wdata = 8'h00;
    @(negedge clk);
    bus_we = 1'b0;
    rd(3'd7, got);
    chk("R7 edge wins over same-cycle clear", got, 8'h81);
    wr(3'd7, 8'h01);
    rd(3'd7, got);
    chk("R7 clear with zero, keep with one", got, 8'h01);
    wr(3'd7, 8'h00);
    wr(3'd7, 8'hFF);
    rd(3'd7, got);
    chk("R7 writing ones sets nothing", got, 8'h00);
    chk("R9 irq low with no flags", {7'd0, irq}, 8'h00);

    pad_in = 8'h0F;
    repeat (4) @(negedge clk);
    wr(3'd7, 8'h00);
    wr(3'd5, 8'hFF);
    wr(3'd5, 8'h00);
    wr(3'd5, 8'h5A);
    wr(3'd5, 8'hA5);
    repeat (4) @(negedge clk);
    rd(3'd7, got);
    chk("R8 edge select change sets no flag", got, 8'h00);
    chk("R8 irq stays low", {7'd0, irq}, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule